// File: doc/BRIEF.md
# Decimal Accumulator Multicycle Processor

This block is a small processor built around one accumulator. Every instruction runs as a fixed series of register transfers through an address latch (MAR) and a memory data register (MDR). A single 100-word memory holds both the program and its data. Each word is a three-digit decimal number stored as packed BCD, four bits per digit. The top digit selects the operation and the lower two digits give a memory address, a jump target or an I/O selector. The accumulator holds a signed value from -999 to 999. A negative flag follows its sign.

In use, the surrounding logic holds the core in reset or idle and fills the memory through a loader port. That port has its own synchronous read path so results can be read back. It then pulses `start`. The core fetches from address 00 and runs until it decodes a halt. An input instruction waits for `in_valid` and acknowledges with a one-cycle `in_take`. An output instruction presents the accumulator as sign plus BCD magnitude and pulses `out_strobe` for one cycle.

Top module: `acc_seq_core`

## Requirements
- R1: After reset `pc_value`, `acc_value`, `neg_flag`, `out_strobe`, `in_take`, `busy` and `halted` are 0. The core stays idle with `pc_value` at 0 until `start` is seen. In idle, a loader write stores `ld_wdata` at `ld_addr`, and `ld_rdata` shows the word at `ld_addr` one clock after the address is applied.
- R2: A word `dxx` decodes by its top digit `d` and its two-digit field `xx`: 1 add, 2 subtract, 3 store, 5 load, 6 jump, 7 jump if accumulator is zero, 8 jump if the negative flag is clear. `901` is input, `902` is output and `000` is halt. Every instruction begins by copying PC into MAR, reading the word into MDR one cycle later, and copying MDR into the instruction register.
- R3: Load sets the accumulator to the word at `xx`. Add and subtract combine the accumulator with that word. Every accumulator result is clamped to the range -999 to 999.
- R4: Store writes the BCD digits of the accumulator's magnitude to address `xx` and drops the sign.
- R5: Every instruction other than a jump or halt ends by incrementing PC by one. The increment wraps from 99 to 00.
- R6: An unconditional jump (`6xx`) loads `xx` into PC and does not increment.
- R7: Jump-if-zero (`7xx`) loads `xx` into PC when the accumulator equals 0. Otherwise it increments PC.
- R8: `neg_flag` is 1 exactly when the accumulator is below zero, updated with every accumulator write. Jump-if-non-negative (`8xx`) is taken when `neg_flag` is 0 and increments PC otherwise.
- R9: Input holds the core, with PC unchanged, until `in_valid` is 1. It then loads the BCD value on `in_data` into the accumulator, clears `neg_flag`, and raises `in_take` for one cycle.
- R10: Output sets `out_data` to the BCD magnitude of the accumulator and `out_neg` to its sign. It pulses `out_strobe` high for exactly one cycle per output instruction and leaves the accumulator unchanged.
- R11: On halt, `halted` goes to 1 and `busy` to 0. PC stays at the halt word's address. No further instruction runs and no register changes until reset.
- R12: Any other word (top digit 4, `0xx` with `xx` non-zero, `9xx` other than 01 or 02) changes nothing except advancing PC by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_we | input | 1 | Loader write enable (use while idle) |
| ld_addr | input | ADDR_W (7) | Loader address, binary 0..99 |
| ld_wdata | input | WORD_W (12) | Loader write word, packed BCD |
| ld_rdata | output | WORD_W (12) | Word at `ld_addr`, one cycle later |
| start | input | 1 | Leave idle and start fetching at 00 |
| in_data | input | WORD_W (12) | Input value, packed BCD |
| in_valid | input | 1 | Input value present |
| in_take | output | 1 | One-cycle pulse: input value accepted |
| out_data | output | WORD_W (12) | Output magnitude, packed BCD |
| out_neg | output | 1 | Output sign |
| out_strobe | output | 1 | One-cycle pulse: new output value |
| acc_value | output | ACC_W (11) | Accumulator, two's complement |
| neg_flag | output | 1 | Accumulator is negative |
| pc_value | output | ADDR_W (7) | Program counter |
| busy | output | 1 | Sequencing instructions |
| halted | output | 1 | Halt reached |

## Verification
The bench sweeps load, subtract and a second add or subtract over boundary operands 0, 1, 499 and 999. This drives results across zero and into both clamps. A core that wraps instead of clamping, or that loses the sign on store or output, shows a wrong accumulator, memory word or `out_neg`. Countdown loops close on jump-if-zero, and subtraction runs test jump-if-non-negative; an inverted or stale condition changes the halt address and the number of output strobes. A self-modifying program runs through the 99-to-00 wrap past an undefined word. It catches a PC that does not wrap, a no-op that alters the accumulator, and a store whose target is fetched stale. An input stall check makes sure the core neither advances nor strobes before `in_valid`.

// File: rtl/acc_seq_pkg.sv
package acc_seq_pkg;

  typedef enum logic [3:0] {
    OP_HLT, OP_ADD, OP_SUB, OP_STA, OP_LDA,
    OP_JMP, OP_JZ, OP_JNN, OP_IN, OP_OUT, OP_NOP
  } op_e;

  typedef enum logic [3:0] {
    S_IDLE, S_F_MAR, S_F_RD, S_F_IR, S_DEC,
    S_X_RD, S_X_ACC, S_X_WR, S_X_IN, S_PC_INC, S_HALT
  } state_e;

  typedef enum logic [1:0] {
    SRC_MEM, SRC_ADD, SRC_SUB, SRC_IN
  } acc_src_e;

  typedef enum logic [1:0] {
    PC_KEEP, PC_STEP, PC_LOAD
  } pc_sel_e;

  // packed BCD (up to 8 digits) to integer
  function automatic int bcd_to_int(input logic [31:0] w, input int nd);
    int v;
    v = 0;
    for (int i = 7; i >= 0; i--) begin
      if (i < nd) v = v * 10 + int'(w[4*i +: 4]);
    end
    return v;
  endfunction

  // non-negative integer to packed BCD (up to 8 digits)
  function automatic logic [31:0] int_to_bcd(input int mag, input int nd);
    logic [31:0] r;
    int m;
    r = '0;
    m = mag;
    for (int i = 0; i < 8; i++) begin
      if (i < nd) begin
        r[4*i +: 4] = 4'(m % 10);
        m = m / 10;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/acc_seq_mem.sv
module acc_seq_mem #(
  parameter int DEPTH  = 100,
  parameter int ADDR_W = 7,
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_we,
  input  logic [WORD_W-1:0] a_wdata,
  output logic [WORD_W-1:0] a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_we,
  input  logic [WORD_W-1:0] b_wdata,
  output logic [WORD_W-1:0] b_rdata
);

  logic [WORD_W-1:0] ram [0:DEPTH-1];

  // one shared write port (core first), two synchronous read ports
  always_ff @(posedge clk) begin
    if (a_we) begin
      if (int'(a_addr) < DEPTH) ram[a_addr] <= a_wdata;
    end else if (b_we) begin
      if (int'(b_addr) < DEPTH) ram[b_addr] <= b_wdata;
    end
  end

  // port A output register is the core's MDR; a store passes its word through
  always_ff @(posedge clk) begin
    if (a_we) a_rdata <= a_wdata;
    else      a_rdata <= ram[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= ram[b_addr];
  end

  // R1: the core only writes inside the 100-word space
  a_r1_core_write_in_range: assert property (@(posedge clk) disable iff (rst)
    a_we |-> (int'(a_addr) < DEPTH));

endmodule

// File: rtl/acc_seq_alu.sv
module acc_seq_alu
  import acc_seq_pkg::*;
#(
  parameter int DIGITS = 3,
  parameter int WORD_W = 12,
  parameter int ACC_W  = 11,
  parameter int MAXV   = 999
) (
  input  logic signed [ACC_W-1:0]  acc,
  input  logic        [WORD_W-1:0] mem_word,
  input  logic        [WORD_W-1:0] in_word,
  input  acc_src_e                 src,
  output logic signed [ACC_W-1:0]  result,
  output logic                     result_neg
);

  int operand;
  int in_val;
  int raw;
  int clamped;

  always_comb begin
    operand = bcd_to_int(32'(mem_word), DIGITS);
    in_val  = bcd_to_int(32'(in_word), DIGITS);
    case (src)
      SRC_MEM: raw = operand;
      SRC_ADD: raw = int'(acc) + operand;
      SRC_SUB: raw = int'(acc) - operand;
      default: raw = in_val;
    endcase
    if (raw > MAXV)       clamped = MAXV;
    else if (raw < -MAXV) clamped = -MAXV;
    else                  clamped = raw;
    result     = ACC_W'(clamped);
    result_neg = (clamped < 0);
  end

endmodule

// File: rtl/acc_seq_ctrl.sv
module acc_seq_ctrl
  import acc_seq_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [3:0]        op_digit,
  input  logic [ADDR_W-1:0] op_field,
  input  logic              acc_zero,
  input  logic              acc_neg,
  input  logic              in_valid,
  output logic              mar_from_pc,
  output logic              mar_from_ir,
  output logic              ir_load,
  output logic              mem_we,
  output logic              acc_load,
  output acc_src_e          acc_src,
  output pc_sel_e           pc_sel,
  output logic              out_load,
  output logic              in_accept,
  output logic              busy,
  output logic              halted
);

  state_e state_q, state_d;
  op_e    op;

  // instruction decode from the registered instruction word
  always_comb begin
    case (op_digit)
      4'd0:    op = (op_field == '0) ? OP_HLT : OP_NOP;
      4'd1:    op = OP_ADD;
      4'd2:    op = OP_SUB;
      4'd3:    op = OP_STA;
      4'd5:    op = OP_LDA;
      4'd6:    op = OP_JMP;
      4'd7:    op = OP_JZ;
      4'd8:    op = OP_JNN;
      4'd9: begin
        if (op_field == ADDR_W'(1))      op = OP_IN;
        else if (op_field == ADDR_W'(2)) op = OP_OUT;
        else                             op = OP_NOP;
      end
      default: op = OP_NOP;
    endcase
  end

  always_comb begin
    state_d     = state_q;
    mar_from_pc = 1'b0;
    mar_from_ir = 1'b0;
    ir_load     = 1'b0;
    mem_we      = 1'b0;
    acc_load    = 1'b0;
    acc_src     = SRC_MEM;
    pc_sel      = PC_KEEP;
    out_load    = 1'b0;
    in_accept   = 1'b0;
    case (state_q)
      S_IDLE:  if (start) state_d = S_F_MAR;
      S_F_MAR: begin
        mar_from_pc = 1'b1;
        state_d     = S_F_RD;
      end
      S_F_RD:  state_d = S_F_IR;
      S_F_IR: begin
        ir_load = 1'b1;
        state_d = S_DEC;
      end
      S_DEC: begin
        case (op)
          OP_ADD, OP_SUB, OP_LDA: begin
            mar_from_ir = 1'b1;
            state_d     = S_X_RD;
          end
          OP_STA: begin
            mar_from_ir = 1'b1;
            state_d     = S_X_WR;
          end
          OP_IN:  state_d = S_X_IN;
          OP_OUT: begin
            out_load = 1'b1;
            state_d  = S_PC_INC;
          end
          OP_JMP: begin
            pc_sel  = PC_LOAD;
            state_d = S_F_MAR;
          end
          OP_JZ: begin
            pc_sel  = acc_zero ? PC_LOAD : PC_STEP;
            state_d = S_F_MAR;
          end
          OP_JNN: begin
            pc_sel  = acc_neg ? PC_STEP : PC_LOAD;
            state_d = S_F_MAR;
          end
          OP_HLT:  state_d = S_HALT;
          default: state_d = S_PC_INC;
        endcase
      end
      S_X_RD:  state_d = S_X_ACC;
      S_X_ACC: begin
        acc_load = 1'b1;
        case (op)
          OP_ADD:  acc_src = SRC_ADD;
          OP_SUB:  acc_src = SRC_SUB;
          default: acc_src = SRC_MEM;
        endcase
        state_d = S_PC_INC;
      end
      S_X_WR: begin
        mem_we  = 1'b1;
        state_d = S_PC_INC;
      end
      S_X_IN: begin
        if (in_valid) begin
          acc_load  = 1'b1;
          acc_src   = SRC_IN;
          in_accept = 1'b1;
          state_d   = S_PC_INC;
        end
      end
      S_PC_INC: begin
        pc_sel  = PC_STEP;
        state_d = S_F_MAR;
      end
      S_HALT:  state_d = S_HALT;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= S_IDLE;
    else     state_q <= state_d;
  end

  assign busy   = (state_q != S_IDLE) && (state_q != S_HALT);
  assign halted = (state_q == S_HALT);

  // R1: idle is left only on start
  a_r1_idle_until_start: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_IDLE && !start) |=> state_q == S_IDLE);

  // R2: the instruction register is only loaded one cycle after the fetch read
  a_r2_ir_after_read: assert property (@(posedge clk) disable iff (rst)
    ir_load |-> $past(state_q) == S_F_RD);

  // R9: the input step holds until valid data arrives
  a_r9_input_stall: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_X_IN && !in_valid) |=> state_q == S_X_IN);

endmodule

// File: rtl/acc_seq_core.sv
module acc_seq_core
  import acc_seq_pkg::*;
#(
  parameter int DIGITS      = 3,
  parameter int ADDR_DIGITS = 2,
  localparam int WORD_W     = 4 * DIGITS,
  localparam int DEPTH      = 10 ** ADDR_DIGITS,
  localparam int ADDR_W     = $clog2(DEPTH),
  localparam int MAXV       = 10 ** DIGITS - 1,
  localparam int ACC_W      = $clog2(MAXV + 1) + 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ld_we,
  input  logic [ADDR_W-1:0]       ld_addr,
  input  logic [WORD_W-1:0]       ld_wdata,
  output logic [WORD_W-1:0]       ld_rdata,
  input  logic                    start,
  input  logic [WORD_W-1:0]       in_data,
  input  logic                    in_valid,
  output logic                    in_take,
  output logic [WORD_W-1:0]       out_data,
  output logic                    out_neg,
  output logic                    out_strobe,
  output logic signed [ACC_W-1:0] acc_value,
  output logic                    neg_flag,
  output logic [ADDR_W-1:0]       pc_value,
  output logic                    busy,
  output logic                    halted
);

  logic [ADDR_W-1:0]       pc_q, mar_q, ir_field;
  logic [WORD_W-1:0]       ir_q, mdr, mag_word;
  logic signed [ACC_W-1:0] acc_q, alu_res;
  logic                    neg_q, alu_neg;
  logic                    mar_from_pc, mar_from_ir, ir_load, mem_we;
  logic                    acc_load, out_load, in_accept;
  acc_src_e                acc_src;
  pc_sel_e                 pc_sel;
  int                      acc_mag;

  // operand field and accumulator magnitude in BCD
  always_comb begin
    ir_field = ADDR_W'(bcd_to_int(32'(ir_q), ADDR_DIGITS));
    acc_mag  = (acc_q < 0) ? -int'(acc_q) : int'(acc_q);
    mag_word = WORD_W'(int_to_bcd(acc_mag, DIGITS));
  end

  acc_seq_mem #(
    .DEPTH  (DEPTH),
    .ADDR_W (ADDR_W),
    .WORD_W (WORD_W)
  ) u_mem (
    .clk     (clk),
    .rst     (rst),
    .a_addr  (mar_q),
    .a_we    (mem_we),
    .a_wdata (mag_word),
    .a_rdata (mdr),
    .b_addr  (ld_addr),
    .b_we    (ld_we),
    .b_wdata (ld_wdata),
    .b_rdata (ld_rdata)
  );

  acc_seq_alu #(
    .DIGITS (DIGITS),
    .WORD_W (WORD_W),
    .ACC_W  (ACC_W),
    .MAXV   (MAXV)
  ) u_alu (
    .acc        (acc_q),
    .mem_word   (mdr),
    .in_word    (in_data),
    .src        (acc_src),
    .result     (alu_res),
    .result_neg (alu_neg)
  );

  acc_seq_ctrl #(
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .op_digit    (ir_q[WORD_W-1 -: 4]),
    .op_field    (ir_field),
    .acc_zero    (acc_q == '0),
    .acc_neg     (neg_q),
    .in_valid    (in_valid),
    .mar_from_pc (mar_from_pc),
    .mar_from_ir (mar_from_ir),
    .ir_load     (ir_load),
    .mem_we      (mem_we),
    .acc_load    (acc_load),
    .acc_src     (acc_src),
    .pc_sel      (pc_sel),
    .out_load    (out_load),
    .in_accept   (in_accept),
    .busy        (busy),
    .halted      (halted)
  );

  // datapath registers
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q       <= '0;
      mar_q      <= '0;
      ir_q       <= '0;
      acc_q      <= '0;
      neg_q      <= 1'b0;
      out_data   <= '0;
      out_neg    <= 1'b0;
      out_strobe <= 1'b0;
      in_take    <= 1'b0;
    end else begin
      if (mar_from_pc)      mar_q <= pc_q;
      else if (mar_from_ir) mar_q <= ir_field;
      if (ir_load) ir_q <= mdr;
      if (acc_load) begin
        acc_q <= alu_res;
        neg_q <= alu_neg;
      end
      case (pc_sel)
        PC_STEP: pc_q <= (int'(pc_q) == DEPTH - 1) ? '0 : pc_q + 1'b1;
        PC_LOAD: pc_q <= ir_field;
        default: pc_q <= pc_q;
      endcase
      out_strobe <= out_load;
      if (out_load) begin
        out_data <= mag_word;
        out_neg  <= (acc_q < 0);
      end
      in_take <= in_accept;
    end
  end

  assign acc_value = acc_q;
  assign neg_flag  = neg_q;
  assign pc_value  = pc_q;

  // R5: the program counter never leaves the memory range
  a_r5_pc_in_range: assert property (@(posedge clk) disable iff (rst)
    int'(pc_q) < DEPTH);

  // R3: the accumulator stays inside the clamp limits
  a_r3_acc_clamped: assert property (@(posedge clk) disable iff (rst)
    (int'(acc_q) <= MAXV) && (int'(acc_q) >= -MAXV));

  // R8: the flag register agrees with the accumulator sign
  a_r8_flag_matches_sign: assert property (@(posedge clk) disable iff (rst)
    neg_q == (acc_q < 0));

  // R10: the output strobe is a single-cycle pulse
  a_r10_strobe_single: assert property (@(posedge clk) disable iff (rst)
    out_strobe |=> !out_strobe);

  // R9: acceptance follows a valid input
  a_r9_take_after_valid: assert property (@(posedge clk) disable iff (rst)
    in_take |-> $past(in_valid));

  // R11: halt is final and freezes the architectural state
  a_r11_halt_frozen: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(pc_q) && $stable(acc_q));

endmodule

// File: tb/acc_seq_core_tb.sv
`timescale 1ns/1ps
module acc_seq_core_tb;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               ld_we = 1'b0;
  logic [6:0]         ld_addr = '0;
  logic [11:0]        ld_wdata = '0;
  logic [11:0]        ld_rdata;
  logic               start = 1'b0;
  logic [11:0]        in_data = '0;
  logic               in_valid = 1'b0;
  logic               in_take;
  logic [11:0]        out_data;
  logic               out_neg;
  logic               out_strobe;
  logic signed [10:0] acc_value;
  logic               neg_flag;
  logic [6:0]         pc_value;
  logic               busy;
  logic               halted;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int n_out = 0;
  int out_vals[32];

  always #2 clk = ~clk;

  acc_seq_core u_dut (
    .clk(clk), .rst(rst), .ld_we(ld_we), .ld_addr(ld_addr), .ld_wdata(ld_wdata),
    .ld_rdata(ld_rdata), .start(start), .in_data(in_data), .in_valid(in_valid),
    .in_take(in_take), .out_data(out_data), .out_neg(out_neg), .out_strobe(out_strobe),
    .acc_value(acc_value), .neg_flag(neg_flag), .pc_value(pc_value), .busy(busy),
    .halted(halted)
  );

  function automatic logic [11:0] bcd3(input int v);
    return {4'((v / 100) % 10), 4'((v / 10) % 10), 4'(v % 10)};
  endfunction

  function automatic int unbcd(input logic [11:0] w);
    return int'(w[11:8]) * 100 + int'(w[7:4]) * 10 + int'(w[3:0]);
  endfunction

  function automatic logic [11:0] ins(input int op, input int adr);
    return bcd3(op * 100 + adr);
  endfunction

  function automatic int clamp(input int v);
    if (v > 999) return 999;
    if (v < -999) return -999;
    return v;
  endfunction

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // record every output strobe as a signed value
  always @(negedge clk) begin
    if (out_strobe) begin
      if (n_out < 32) out_vals[n_out] = out_neg ? -unbcd(out_data) : unbcd(out_data);
      n_out++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic put(input int a, input logic [11:0] w);
    @(negedge clk);
    ld_we = 1'b1;
    ld_addr = 7'(a);
    ld_wdata = w;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic peek(input int a, output int v);
    @(negedge clk);
    ld_addr = 7'(a);
    @(negedge clk);
    v = unbcd(ld_rdata);
  endtask

  task automatic launch();
    n_out = 0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_halt(input string req);
    int cyc;
    cyc = 0;
    while (!halted && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    chk({req, " halt reached"}, int'(halted), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v;
    int vals[4] = '{0, 1, 499, 999};

    // R1: reset state, idle hold, loader access
    do_reset();
    chk("R1 pc", int'(pc_value), 0);
    chk("R1 acc", int'(acc_value), 0);
    chk("R1 neg", int'(neg_flag), 0);
    chk("R1 strobe", int'(out_strobe), 0);
    chk("R1 take", int'(in_take), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 halted", int'(halted), 0);
    for (int a = 0; a < 100; a++) put(a, 12'h000);
    put(50, 12'h123);
    peek(50, v);
    chk("R1 loader readback", v, 123);
    peek(51, v);
    chk("R1 loader neighbour", v, 0);
    repeat (10) @(negedge clk);
    chk("R1 idle pc", int'(pc_value), 0);
    chk("R1 idle busy", int'(busy), 0);

    // R2 R3 R4 R10: load, subtract, add or subtract, store, output sweep
    for (int ai = 0; ai < 4; ai++)
      for (int bi = 0; bi < 4; bi++)
        for (int ci = 0; ci < 4; ci++)
          for (int sub2 = 0; sub2 < 2; sub2++) begin
            int e1, e;
            e1 = clamp(vals[ai] - vals[bi]);
            e  = (sub2 != 0) ? clamp(e1 - vals[ci]) : clamp(e1 + vals[ci]);
            do_reset();
            put(0, ins(5, 90));
            put(1, ins(2, 91));
            put(2, ins((sub2 != 0) ? 2 : 1, 93));
            put(3, ins(3, 92));
            put(4, 12'h902);
            put(5, 12'h000);
            put(90, bcd3(vals[ai]));
            put(91, bcd3(vals[bi]));
            put(93, bcd3(vals[ci]));
            launch();
            wait_halt("R2");
            chk("R3 acc result", int'(acc_value), e);
            chk("R8 neg flag", int'(neg_flag), int'(e < 0));
            chk("R11 halt pc", int'(pc_value), 5);
            chk("R10 strobe count", n_out, 1);
            chk("R10 output value", out_vals[0], e);
            peek(92, v);
            chk("R4 stored magnitude", v, iabs(e));
          end

    // R11: nothing moves after halt
    repeat (15) @(negedge clk);
    chk("R11 pc frozen", int'(pc_value), 5);
    chk("R11 busy low", int'(busy), 0);
    chk("R11 no extra strobe", n_out, 1);

    // R7 R6: countdown loop closed by jump-if-zero
    for (int n = 0; n < 6; n++) begin
      do_reset();
      put(0, ins(5, 20));
      put(1, ins(7, 6));
      put(2, ins(2, 21));
      put(3, 12'h902);
      put(4, ins(6, 1));
      put(5, ins(6, 5));
      put(6, 12'h000);
      put(20, bcd3(n));
      put(21, bcd3(1));
      launch();
      wait_halt("R7");
      chk("R7 exit address", int'(pc_value), 6);
      chk("R6 loop outputs", n_out, n);
      for (int k = 0; k < n && k < 32; k++) chk("R7 countdown value", out_vals[k], n - 1 - k);
    end

    // R8: jump-if-non-negative after subtract
    for (int ai = 0; ai < 3; ai++)
      for (int bi = 0; bi < 3; bi++) begin
        int a, b;
        a = ai * 3;
        b = bi * 3;
        do_reset();
        put(0, ins(5, 20));
        put(1, ins(2, 21));
        put(2, ins(8, 5));
        put(3, 12'h902);
        put(4, 12'h000);
        put(5, 12'h000);
        put(20, bcd3(a));
        put(21, bcd3(b));
        launch();
        wait_halt("R8");
        chk("R8 branch target", int'(pc_value), (a - b >= 0) ? 5 : 4);
        chk("R8 not-taken outputs", n_out, (a - b >= 0) ? 0 : 1);
        if (a - b < 0) chk("R10 negative output", out_vals[0], a - b);
      end

    // R9: input stall, accept, then add and output
    do_reset();
    put(0, 12'h901);
    put(1, ins(1, 10));
    put(2, 12'h902);
    put(3, 12'h000);
    put(10, bcd3(25));
    launch();
    repeat (20) @(negedge clk);
    chk("R9 stalled pc", int'(pc_value), 0);
    chk("R9 stalled busy", int'(busy), 1);
    chk("R9 no output while stalled", n_out, 0);
    chk("R9 acc untouched", int'(acc_value), 0);
    in_data = bcd3(640);
    in_valid = 1'b1;
    begin
      int cyc;
      cyc = 0;
      while (!in_take && cyc < 50) begin
        @(negedge clk);
        cyc++;
      end
    end
    chk("R9 take pulse", int'(in_take), 1);
    chk("R9 acc loaded", int'(acc_value), 640);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R9 take single cycle", int'(in_take), 0);
    wait_halt("R9");
    chk("R9 final acc", int'(acc_value), 665);
    chk("R10 output after input", out_vals[0], 665);

    // R5 R12: wrap 99 to 00, undefined word, store into code
    do_reset();
    put(0, ins(6, 95));
    put(95, ins(5, 21));
    put(96, 12'h433);
    put(97, 12'h902);
    put(98, ins(2, 21));
    put(99, ins(3, 0));
    put(21, bcd3(42));
    launch();
    wait_halt("R5");
    chk("R5 wrapped to 00", int'(pc_value), 0);
    chk("R12 undefined kept acc", out_vals[0], 42);
    chk("R12 one output", n_out, 1);
    chk("R3 acc zero", int'(acc_value), 0);
    peek(0, v);
    chk("R4 store into code", v, 0);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule